// File: doc/BRIEF.md
# Network-Interface Victim Line Store

This block sits in a tile's network interface, on the path between the private L1 cache and the on-chip network. It keeps lines that the L1 dropped on conflict or capacity replacement. Each outgoing L1 miss is checked against these lines before it leaves the tile. When a stored line matches, it goes straight back to the L1 and the network never sees the request. When nothing matches, the request goes out toward its home tile unchanged.

The store is fully associative and exclusive. A hit removes the line rather than swapping it. Entries are filled at the first free slot. When every slot is valid, a round-robin pointer chooses the slot to overwrite. Because the L1 only evicts clean or already written-back lines, a displaced line is simply dropped. Eviction inserts are always taken. A miss request is taken when `mq_ready` is high, and it gets exactly one response, one cycle later.

Top module: `l1_victim_store`

## Requirements
- R1: After reset every entry is invalid, `fill_valid` and `fwd_valid` are 0 and `mq_ready` is 1, so the first lookup of any address misses.
- R2: An eviction (`ev_valid` high for one cycle) stores the line and its address, and a later lookup of that address returns exactly that line.
- R3: All `ENTRIES` slots can be matched: after `ENTRIES` distinct addresses are inserted into an empty store, each of them hits.
- R4: A request accepted on edge T that hits raises `fill_valid` for exactly the cycle after T, with `fill_addr` equal to the request address and `fill_data` equal to the stored line.
- R5: A request accepted on edge T that misses raises `fwd_valid` after T with `fwd_addr` equal to the request address. `fwd_valid` and `fwd_addr` then hold, with `mq_ready` low, until an edge where `fwd_ready` is high. After that edge `fwd_valid` is 0 and `mq_ready` is 1.
- R6: A hit invalidates the matching entry, so a second lookup of the same address misses and is forwarded.
- R7: With all slots valid, a new address replaces the slot chosen by a round-robin pointer. From an empty store this is the oldest insert, and the displaced address then misses.
- R8: Inserting an address that is already stored overwrites that entry without creating a duplicate. A lookup returns the newer line, and a second lookup then misses.
- R9: When an eviction and an accepted request carry the same address in one cycle, the request hits with the evicted line and that line is not kept, so the next lookup of it misses.
- R10: When an eviction and an accepted request carry different addresses in one cycle, the request is resolved against the contents from before the insert, and the insert still takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_valid | input | 1 | L1 eviction strobe |
| ev_addr | input | ADDR_W | Line address of the evicted line |
| ev_data | input | WORD_W*WORDS | Evicted line data |
| mq_valid | input | 1 | Outgoing L1 miss request valid |
| mq_ready | output | 1 | Request can be accepted |
| mq_addr | input | ADDR_W | Miss line address |
| fill_valid | output | 1 | Hit line returned to L1 (one-cycle pulse) |
| fill_addr | output | ADDR_W | Address of the returned line |
| fill_data | output | WORD_W*WORDS | Returned line data |
| fwd_valid | output | 1 | Missed request offered to the network |
| fwd_addr | output | ADDR_W | Forwarded line address |
| fwd_ready | input | 1 | Network takes the forwarded request |

## Verification
The checker watches these properties on every cycle:
- A fill and a forward are never active together.
- Every response follows an accepted request one cycle earlier and carries that request's address.
- A stalled forward stays stable.
- No address is ever held twice.
- An eviction that is not bypassed is present on the next cycle, and a bypassed one is absent.

Some properties can only be shown by the bench's scenarios, because they depend on the stored contents: that hit data is correct, that invalidation turns a later lookup into a miss, and which slot the round-robin pointer replaces.

// File: rtl/vstore_pkg.sv
package vstore_pkg;
  typedef enum logic [1:0] {
    RSP_IDLE = 2'd0,
    RSP_FILL = 2'd1,
    RSP_FWD  = 2'd2
  } rsp_state_e;
endpackage

// File: rtl/vstore_match.sv
module vstore_match #(
  parameter int ENTRIES = 16,
  parameter int ADDR_W  = 26,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] valid_i,
  input  logic [ADDR_W-1:0]  tag_i [ENTRIES],
  input  logic [ADDR_W-1:0]  key_i,
  output logic               hit_o,
  output logic [IDX_W-1:0]   idx_o
);
  logic [ENTRIES-1:0] eq;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign eq[g] = valid_i[g] && (tag_i[g] == key_i);
  end

  always_comb begin
    idx_o = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (eq[i]) idx_o = IDX_W'(i);
    end
  end

  assign hit_o = |eq;
endmodule

// File: rtl/vstore_alloc.sv
module vstore_alloc #(
  parameter int ENTRIES = 16,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] valid_i,
  input  logic               advance_i,
  output logic               free_ok_o,
  output logic [IDX_W-1:0]   free_idx_o,
  output logic [IDX_W-1:0]   rep_idx_o
);
  logic [IDX_W-1:0] ptr_q, ptr_d;

  always_comb begin
    free_idx_o = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_i[i]) free_idx_o = IDX_W'(i);
    end
  end

  assign free_ok_o = ~&valid_i;
  assign rep_idx_o = ptr_q;

  always_comb begin
    ptr_d = ptr_q;
    if (advance_i) begin
      ptr_d = (ptr_q == IDX_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end
endmodule

// File: rtl/l1_victim_store.sv
module l1_victim_store
  import vstore_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int ADDR_W  = 26,
  parameter int WORD_W  = 32,
  parameter int WORDS   = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ev_valid,
  input  logic [ADDR_W-1:0]       ev_addr,
  input  logic [WORD_W*WORDS-1:0] ev_data,
  input  logic                    mq_valid,
  output logic                    mq_ready,
  input  logic [ADDR_W-1:0]       mq_addr,
  output logic                    fill_valid,
  output logic [ADDR_W-1:0]       fill_addr,
  output logic [WORD_W*WORDS-1:0] fill_data,
  output logic                    fwd_valid,
  output logic [ADDR_W-1:0]       fwd_addr,
  input  logic                    fwd_ready
);
  localparam int LINE_W = WORD_W * WORDS;
  localparam int IDX_W  = $clog2(ENTRIES);

  logic [ENTRIES-1:0] valid_q, valid_d;
  logic [ADDR_W-1:0]  tag_q  [ENTRIES];
  logic [LINE_W-1:0]  data_q [ENTRIES];
  rsp_state_e         rsp_q, rsp_d;
  logic [ADDR_W-1:0]  rsp_addr_q, rsp_addr_d;
  logic [LINE_W-1:0]  rsp_data_q, rsp_data_d;

  logic             accept, bypass, do_insert, advance;
  logic             lk_hit, in_hit, free_ok, resp_hit;
  logic [IDX_W-1:0] lk_idx, in_idx, free_idx, rep_idx, ins_idx;
  logic [LINE_W-1:0] resp_data;

  assign mq_ready = (rsp_q != RSP_FWD);
  assign accept   = mq_valid && mq_ready;

  vstore_match #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_lookup (
    .valid_i (valid_q), .tag_i (tag_q), .key_i (mq_addr),
    .hit_o (lk_hit), .idx_o (lk_idx)
  );

  vstore_match #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_insmatch (
    .valid_i (valid_q), .tag_i (tag_q), .key_i (ev_addr),
    .hit_o (in_hit), .idx_o (in_idx)
  );

  assign bypass    = accept && ev_valid && (ev_addr == mq_addr);
  assign do_insert = ev_valid && !bypass;
  assign advance   = do_insert && !in_hit && !free_ok;

  vstore_alloc #(.ENTRIES(ENTRIES)) u_alloc (
    .clk (clk), .rst_n (rst_n), .valid_i (valid_q), .advance_i (advance),
    .free_ok_o (free_ok), .free_idx_o (free_idx), .rep_idx_o (rep_idx)
  );

  always_comb begin
    if (in_hit)       ins_idx = in_idx;
    else if (free_ok) ins_idx = free_idx;
    else              ins_idx = rep_idx;
  end

  assign resp_hit  = bypass || lk_hit;
  assign resp_data = bypass ? ev_data : data_q[lk_idx];

  // lookup resolves first: invalidate, then let the insert claim its slot
  always_comb begin
    valid_d = valid_q;
    if (accept && lk_hit) valid_d[lk_idx] = 1'b0;
    if (do_insert)        valid_d[ins_idx] = 1'b1;
  end

  always_comb begin
    rsp_d      = rsp_q;
    rsp_addr_d = rsp_addr_q;
    rsp_data_d = rsp_data_q;
    if (rsp_q == RSP_FWD) begin
      if (fwd_ready) rsp_d = RSP_IDLE;
    end else if (accept) begin
      rsp_d      = resp_hit ? RSP_FILL : RSP_FWD;
      rsp_addr_d = mq_addr;
      if (resp_hit) rsp_data_d = resp_data;
    end else begin
      rsp_d = RSP_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      rsp_q   <= RSP_IDLE;
    end else begin
      valid_q <= valid_d;
      rsp_q   <= rsp_d;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) rsp_addr_q <= rsp_addr_d;
    if (accept && resp_hit) rsp_data_q <= rsp_data_d;
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
    logic wr_en;
    assign wr_en = do_insert && (ins_idx == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (wr_en) begin
        tag_q[g]  <= ev_addr;
        data_q[g] <= ev_data;
      end
    end
  end

  assign fill_valid = (rsp_q == RSP_FILL);
  assign fill_addr  = rsp_addr_q;
  assign fill_data  = rsp_data_q;
  assign fwd_valid  = (rsp_q == RSP_FWD);
  assign fwd_addr   = rsp_addr_q;
endmodule

// File: rtl/vstore_chk.sv
module vstore_chk #(
  parameter int ENTRIES = 16,
  parameter int ADDR_W  = 26
) (
  input logic               clk,
  input logic               rst_n,
  input logic               ev_valid,
  input logic [ADDR_W-1:0]  ev_addr,
  input logic               mq_valid,
  input logic               mq_ready,
  input logic [ADDR_W-1:0]  mq_addr,
  input logic               fill_valid,
  input logic [ADDR_W-1:0]  fill_addr,
  input logic               fwd_valid,
  input logic [ADDR_W-1:0]  fwd_addr,
  input logic               fwd_ready,
  input logic [ENTRIES-1:0] valid_q,
  input logic [ADDR_W-1:0]  tag_q [ENTRIES]
);
  logic              dup, present_last, last_ins, last_byp;
  logic [ADDR_W-1:0] last_addr;

  always_comb begin
    dup = 1'b0;
    present_last = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (valid_q[i] && tag_q[i] == last_addr) present_last = 1'b1;
      for (int j = i + 1; j < ENTRIES; j++) begin
        if (valid_q[i] && valid_q[j] && tag_q[i] == tag_q[j]) dup = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_ins  <= 1'b0;
      last_byp  <= 1'b0;
      last_addr <= '0;
    end else begin
      last_addr <= ev_addr;
      last_byp  <= ev_valid && mq_valid && mq_ready && (ev_addr == mq_addr);
      last_ins  <= ev_valid && !(mq_valid && mq_ready && (ev_addr == mq_addr));
    end
  end

  AST_RESP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(fill_valid && fwd_valid)); // R5
  AST_FILL_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fill_valid) |-> $past(mq_valid && mq_ready)); // R4
  AST_FILL_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (mq_valid && mq_ready) |=> ((fill_valid || fwd_valid) && fill_addr == $past(mq_addr))); // R4
  AST_FWD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_valid && !fwd_ready) |=> (fwd_valid && $stable(fwd_addr))); // R5
  AST_FWD_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid |-> !mq_ready); // R5
  AST_NO_DUP_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    !dup); // R8
  AST_EV_STORED: assert property (@(posedge clk) disable iff (!rst_n)
    last_ins |-> present_last); // R2
  AST_BYPASS_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    last_byp |-> !present_last); // R9
endmodule

bind l1_victim_store vstore_chk #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_chk (
  .clk (clk), .rst_n (rst_n), .ev_valid (ev_valid), .ev_addr (ev_addr),
  .mq_valid (mq_valid), .mq_ready (mq_ready), .mq_addr (mq_addr),
  .fill_valid (fill_valid), .fill_addr (fill_addr),
  .fwd_valid (fwd_valid), .fwd_addr (fwd_addr), .fwd_ready (fwd_ready),
  .valid_q (valid_q), .tag_q (tag_q)
);

// File: tb/l1_victim_store_tb.sv
`timescale 1ns/1ps
module l1_victim_store_tb;
  localparam int ENTRIES = 16;
  localparam int ADDR_W  = 26;
  localparam int LINE_W  = 128;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_valid = 1'b0, mq_valid = 1'b0, fwd_ready = 1'b0;
  logic [ADDR_W-1:0] ev_addr = '0, mq_addr = '0;
  logic [LINE_W-1:0] ev_data = '0;
  logic mq_ready, fill_valid, fwd_valid;
  logic [ADDR_W-1:0] fill_addr, fwd_addr;
  logic [LINE_W-1:0] fill_data;

  int n_cmp = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  l1_victim_store u_dut (
    .clk (clk), .rst_n (rst_n),
    .ev_valid (ev_valid), .ev_addr (ev_addr), .ev_data (ev_data),
    .mq_valid (mq_valid), .mq_ready (mq_ready), .mq_addr (mq_addr),
    .fill_valid (fill_valid), .fill_addr (fill_addr), .fill_data (fill_data),
    .fwd_valid (fwd_valid), .fwd_addr (fwd_addr), .fwd_ready (fwd_ready)
  );

  typedef struct packed {
    logic              is_lookup;
    logic [ADDR_W-1:0] addr;
    logic [31:0]       seed;
    logic              exp_hit;
  } vec_t;

  localparam vec_t VECS [12] = '{
    '{1'b0, 26'h0A0, 32'h1000, 1'b0},  // R2 insert A
    '{1'b1, 26'h0A0, 32'h1000, 1'b1},  // R2 lookup A hit
    '{1'b1, 26'h0A0, 32'h0,    1'b0},  // R6 A gone
    '{1'b1, 26'h0B0, 32'h0,    1'b0},  // R5 B miss
    '{1'b0, 26'h0B0, 32'h2000, 1'b0},  // R8 insert B old
    '{1'b0, 26'h0B0, 32'h3000, 1'b0},  // R8 insert B new
    '{1'b1, 26'h0B0, 32'h3000, 1'b1},  // R8 newer line
    '{1'b1, 26'h0B0, 32'h0,    1'b0},  // R8 no duplicate left
    '{1'b0, 26'h0C0, 32'h4000, 1'b0},
    '{1'b0, 26'h0D0, 32'h5000, 1'b0},
    '{1'b1, 26'h0D0, 32'h5000, 1'b1},  // R2
    '{1'b1, 26'h0C0, 32'h4000, 1'b1}   // R2
  };

  function automatic logic [LINE_W-1:0] mkline(input logic [31:0] s);
    return {s + 32'd3, s + 32'd2, s + 32'd1, s};
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [LINE_W-1:0] act, input logic [LINE_W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic do_insert(input logic [ADDR_W-1:0] a, input logic [31:0] s);
    @(negedge clk);
    ev_valid = 1'b1; ev_addr = a; ev_data = mkline(s);
    @(negedge clk);
    ev_valid = 1'b0;
  endtask

  // optional same-cycle eviction (with_ev) alongside the lookup
  task automatic do_lookup(input string req, input logic [ADDR_W-1:0] a,
                           input logic exp_hit, input logic [31:0] s,
                           input logic with_ev, input logic [ADDR_W-1:0] ea,
                           input logic [31:0] es);
    @(negedge clk);
    mq_valid = 1'b1; mq_addr = a;
    if (with_ev) begin ev_valid = 1'b1; ev_addr = ea; ev_data = mkline(es); end
    chk(req, "ready before accept", LINE_W'(mq_ready), LINE_W'(1));
    @(negedge clk);
    mq_valid = 1'b0; ev_valid = 1'b0;
    chk(req, "fill_valid", LINE_W'(fill_valid), LINE_W'(exp_hit));
    chk(req, "fwd_valid", LINE_W'(fwd_valid), LINE_W'(!exp_hit));
    if (exp_hit) begin
      chk(req, "fill_addr", LINE_W'(fill_addr), LINE_W'(a));
      chk(req, "fill_data", fill_data, mkline(s));
      @(negedge clk);
      chk("R4", "fill pulse ends", LINE_W'(fill_valid), LINE_W'(0));
    end else begin
      chk("R5", "fwd_addr", LINE_W'(fwd_addr), LINE_W'(a));
      chk("R5", "ready low while forwarding", LINE_W'(mq_ready), LINE_W'(0));
      @(negedge clk);
      chk("R5", "fwd held", LINE_W'(fwd_valid), LINE_W'(1));
      chk("R5", "fwd_addr held", LINE_W'(fwd_addr), LINE_W'(a));
      fwd_ready = 1'b1;
      @(negedge clk);
      fwd_ready = 1'b0;
      chk("R5", "fwd released", LINE_W'(fwd_valid), LINE_W'(0));
      chk("R5", "ready restored", LINE_W'(mq_ready), LINE_W'(1));
    end
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "fill_valid", LINE_W'(fill_valid), LINE_W'(0));
    chk("R1", "fwd_valid", LINE_W'(fwd_valid), LINE_W'(0));
    chk("R1", "mq_ready", LINE_W'(mq_ready), LINE_W'(1));
    do_lookup("R1", 26'h0A0, 1'b0, 0, 1'b0, '0, 0);

    for (int i = 0; i < 12; i++) begin
      if (VECS[i].is_lookup)
        do_lookup("R2", VECS[i].addr, VECS[i].exp_hit, VECS[i].seed, 1'b0, '0, 0);
      else
        do_insert(VECS[i].addr, VECS[i].seed);
    end

    // R3 all slots reachable
    for (int i = 0; i < ENTRIES; i++) do_insert(26'h100 + 26'(i), 32'h10000 + 32'(i * 16));
    for (int i = ENTRIES - 1; i >= 0; i--)
      do_lookup("R3", 26'h100 + 26'(i), 1'b1, 32'h10000 + 32'(i * 16), 1'b0, '0, 0);

    // R7 replacement of oldest
    for (int i = 0; i < ENTRIES; i++) do_insert(26'h100 + 26'(i), 32'h20000 + 32'(i * 16));
    do_insert(26'h200, 32'h30000);
    do_lookup("R7", 26'h100, 1'b0, 0, 1'b0, '0, 0);
    do_lookup("R7", 26'h200, 1'b1, 32'h30000, 1'b0, '0, 0);
    do_lookup("R7", 26'h101, 1'b1, 32'h20010, 1'b0, '0, 0);
    do_lookup("R7", 26'h10F, 1'b1, 32'h200F0, 1'b0, '0, 0);

    // R9 same-cycle insert and lookup, same address
    do_lookup("R9", 26'h300, 1'b1, 32'h40000, 1'b1, 26'h300, 32'h40000);
    do_lookup("R9", 26'h300, 1'b0, 0, 1'b0, '0, 0);

    // R10 same-cycle, different addresses
    do_insert(26'h400, 32'h50000);
    do_lookup("R10", 26'h400, 1'b1, 32'h50000, 1'b1, 26'h401, 32'h60000);
    do_lookup("R10", 26'h401, 1'b1, 32'h60000, 1'b0, '0, 0);
    do_lookup("R10", 26'h403, 1'b0, 0, 1'b1, 26'h402, 32'h70000);
    do_lookup("R10", 26'h402, 1'b1, 32'h70000, 1'b0, '0, 0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule